// File: doc/BRIEF.md
# PWM Sample Word Queue with Prefetch

This block buffers 32-bit sample words on their way from a bus or DMA engine to a pair of PWM waveform counters. Words enter through a valid/ready push port and are stored oldest-first. A level-type DMA request stays high for as long as the number of stored words is strictly below a programmable threshold. The request does not depend on whether any PWM channel is enabled, so the queue fills up before output starts.

When the first channel is enabled, the block moves words out of the queue in the same cycle. Each channel owns a current-sample register, which drives its sample output, and a one-word holding register. The waveform counters pulse a per-channel strobe at each period boundary. The strobe hands the held word to the current register, and the holding register then refills from the queue.

With one channel enabled, the last word repeats for ever. With both channels enabled, words alternate between the channels. An underrun then either stops both channels and raises sticky gap flags, or repeats the last samples when both repeat inputs are set.

The push port follows these back-pressure rules. A word is taken on any clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` depends only on the stored word count. A producer may hold `wr_valid` and `wr_data` steady while `wr_ready` is 0.

Top module: `pwm_wfifo`

## Requirements
- R1: `dreq` is 1 exactly when the stored word count is strictly less than `dreq_thr`, whether or not a channel is enabled.
- R2: With `dreq_thr` equal to 0, `dreq` stays 0 at every occupancy.
- R3: `empty` is 1 exactly when no word is stored; after reset `empty` is 1 and both sample outputs are 0.
- R4: A push is accepted when `wr_valid` and `wr_ready` are both 1. `wr_ready` is 0 exactly when DEPTH words are stored, and a refused push leaves the queue unchanged.
- R5: When only one channel becomes enabled (all enables were 0 in the previous cycle), two words are popped if at least two are stored, otherwise one. The oldest word appears on that channel's sample output one cycle later and the second is held. With nothing stored, the sample becomes 0.
- R6: In single-channel operation, a strobe on the enabled channel copies the held word to its sample output on the next cycle. An empty holding register is refilled with the oldest stored word, at most one pop per cycle.
- R7: In single-channel operation, a strobe with an empty holding register leaves the sample unchanged. `rpt_a` and `rpt_b` have no effect, and the enabled channel's state flag stays 1 from the cycle after enable while it stays enabled.
- R8: When both channels become enabled together from all-off, up to four words are popped, in order, into current A, current B, held A and held B. A current register left without a word becomes 0.
- R9: In dual-channel operation, holding registers are refilled in strict alternation A, B, A, ..., starting with A after enable. A refill waits until the target register is empty.
- R10: In dual-channel operation without repeat (`rpt_a` and `rpt_b` not both 1), a strobe on an enabled channel whose holding register is empty stops output. From the next cycle `state_a` and `state_b` are 0 and `gap_a` and `gap_b` are 1, and no further pops occur until both enables return to 0.
- R11: In dual-channel operation with `rpt_a` and `rpt_b` both 1, an underrunning strobe keeps the current sample, and output continues.
- R12: Each gap flag stays 1 until a cycle with its clear input at 1. A simultaneous stop event wins over the clear.
- R13: While both enables are 0, both state flags are 0, held words are discarded, and nothing is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Push request |
| wr_ready | output | 1 | Queue can accept a word |
| wr_data | input | DW | Word to push |
| dreq_thr | input | CW | Request threshold in words, 0 disables requests |
| dreq | output | 1 | Level DMA request |
| empty | output | 1 | Queue holds no word |
| en_a | input | 1 | Channel A enable |
| en_b | input | 1 | Channel B enable |
| rpt_a | input | 1 | Repeat control A (dual mode repeats only when both are set) |
| rpt_b | input | 1 | Repeat control B |
| strobe_a | input | 1 | Channel A period boundary, consumes a sample |
| strobe_b | input | 1 | Channel B period boundary, consumes a sample |
| samp_a | output | DW | Channel A current sample |
| samp_b | output | DW | Channel B current sample |
| state_a | output | 1 | Channel A producing output |
| state_b | output | 1 | Channel B producing output |
| gap_a | output | 1 | Sticky gap flag A |
| gap_b | output | 1 | Sticky gap flag B |
| gap_clr_a | input | 1 | Clears gap A |
| gap_clr_b | input | 1 | Clears gap B |

## Verification
The bench builds the block with DW = 32 and DEPTH = 8, so CW is 4. The shallow queue fills, refuses writes and drains within a few dozen cycles. The 4-bit threshold can be swept from 0 to above the depth, which reaches both the request-at-full case and the never-request case. A depth of eight also lets the four-word dual prefetch run with the queue full, with one word stored, and with the queue empty.

// File: rtl/pwm_wfifo_pkg.sv
package pwm_wfifo_pkg;
  localparam int NCH      = 2;  // channels fed by the queue
  localparam int PF_DUAL  = 4;  // words moved at a dual-channel start
  localparam int PF_ONE   = 2;  // words moved at a single-channel start
  localparam int POPW     = 3;  // width of a pop count

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ONE  = 2'd1,
    MODE_DUAL = 2'd2
  } feed_mode_e;
endpackage

// File: rtl/pwm_wfifo_mem.sv
module pwm_wfifo_mem
  import pwm_wfifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int NRD   = PF_DUAL,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [DW-1:0]           push_data,
  input  logic [POPW-1:0]         pop_n,
  output logic [CW-1:0]           cnt,
  output logic [NRD-1:0][DW-1:0]  head
);
  logic [DW-1:0] store [DEPTH];
  logic [AW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] cnt_q;

  // read window: the NRD oldest entries, valid up to cnt
  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign head[k] = store[AW'(rptr_q + AW'(k))];
  end

  always_ff @(posedge clk) begin
    if (push) store[wptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= AW'(rptr_q + AW'(pop_n));
      if (push) wptr_q <= AW'(wptr_q + AW'(1));
      cnt_q  <= CW'(cnt_q + CW'(push) - CW'(pop_n));
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwm_wfifo_req.sv
module pwm_wfifo_req #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] thr,
  output logic          dreq,
  output logic          empty,
  output logic          ready
);
  // strictly-below compare: a zero threshold can never be exceeded
  assign dreq  = cnt < thr;
  assign empty = cnt == '0;
  assign ready = cnt < CW'(DEPTH);
endmodule

// File: rtl/pwm_wfifo_feed.sv
module pwm_wfifo_feed
  import pwm_wfifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             en,
  input  logic [NCH-1:0]             rpt,
  input  logic [NCH-1:0]             strobe,
  input  logic [CW-1:0]              cnt,
  input  logic [PF_DUAL-1:0][DW-1:0] head,
  output logic [NCH-1:0][DW-1:0]     samp,
  output logic [POPW-1:0]            pop_n,
  output logic                       stop_hit,
  output logic                       live
);
  feed_mode_e mode;
  logic act_q, stop_q, nxt_q;
  logic stop_n, nxt_n;
  logic [NCH-1:0][DW-1:0] cur_q, cur_n, hold_q, hold_n;
  logic [NCH-1:0]         hv_q, hv_n;
  logic                   sel_one;   // channel index in single mode
  logic                   tgt;       // refill target
  logic                   rep_dual;
  logic                   start, run;

  always_comb begin
    if (&en)      mode = MODE_DUAL;
    else if (|en) mode = MODE_ONE;
    else          mode = MODE_OFF;
  end

  assign sel_one  = en[1] & ~en[0];
  assign rep_dual = &rpt;
  assign start    = (mode != MODE_OFF) && !act_q;
  assign run      = (mode != MODE_OFF) && act_q && !stop_q;
  assign tgt      = (mode == MODE_DUAL) ? nxt_q : sel_one;

  always_comb begin
    cur_n    = cur_q;
    hold_n   = hold_q;
    hv_n     = hv_q;
    stop_n   = stop_q;
    nxt_n    = nxt_q;
    pop_n    = '0;
    stop_hit = 1'b0;
    if (mode == MODE_OFF) begin
      hv_n   = '0;
      stop_n = 1'b0;
    end else if (start) begin
      stop_n = 1'b0;
      nxt_n  = 1'b0;
      hv_n   = '0;
      if (mode == MODE_DUAL) begin
        cur_n[0]  = (cnt > CW'(0)) ? head[0] : '0;
        cur_n[1]  = (cnt > CW'(1)) ? head[1] : '0;
        hold_n[0] = head[2];
        hold_n[1] = head[3];
        hv_n[0]   = cnt > CW'(2);
        hv_n[1]   = cnt > CW'(3);
        pop_n     = (cnt > CW'(3)) ? POPW'(PF_DUAL) : POPW'(cnt);
      end else begin
        cur_n[sel_one]  = (cnt > CW'(0)) ? head[0] : '0;
        hold_n[sel_one] = head[1];
        hv_n[sel_one]   = cnt > CW'(1);
        pop_n           = (cnt > CW'(1)) ? POPW'(PF_ONE) : POPW'(cnt);
      end
    end else if (run) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (strobe[ch] && en[ch]) begin
          if (hv_q[ch]) begin
            cur_n[ch] = hold_q[ch];
            hv_n[ch]  = 1'b0;
          end else if (mode == MODE_DUAL && !rep_dual) begin
            stop_hit = 1'b1;
          end
        end
      end
      if (stop_hit) begin
        stop_n = 1'b1;
      end else if (!hv_n[tgt] && cnt != '0) begin
        hold_n[tgt] = head[0];
        hv_n[tgt]   = 1'b1;
        pop_n       = POPW'(1);
        if (mode == MODE_DUAL) nxt_n = ~nxt_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      stop_q <= 1'b0;
      nxt_q  <= 1'b0;
      cur_q  <= '0;
      hold_q <= '0;
      hv_q   <= '0;
    end else begin
      act_q  <= mode != MODE_OFF;
      stop_q <= stop_n;
      nxt_q  <= nxt_n;
      cur_q  <= cur_n;
      hold_q <= hold_n;
      hv_q   <= hv_n;
    end
  end

  assign samp = cur_q;
  assign live = act_q & ~stop_q;
endmodule

// File: rtl/pwm_wfifo_flag.sv
module pwm_wfifo_flag
  import pwm_wfifo_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stop_hit,
  input  logic           live,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] gap_clr,
  output logic [NCH-1:0] gap,
  output logic [NCH-1:0] state
);
  logic [NCH-1:0] gap_q;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_gap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            gap_q[ch] <= 1'b0;
      else if (stop_hit)     gap_q[ch] <= 1'b1;
      else if (gap_clr[ch])  gap_q[ch] <= 1'b0;
    end
  end

  assign gap   = gap_q;
  assign state = en & {NCH{live}};
endmodule

// File: rtl/pwm_wfifo.sv
module pwm_wfifo
  import pwm_wfifo_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] dreq_thr,
  output logic          dreq,
  output logic          empty,
  input  logic          en_a,
  input  logic          en_b,
  input  logic          rpt_a,
  input  logic          rpt_b,
  input  logic          strobe_a,
  input  logic          strobe_b,
  output logic [DW-1:0] samp_a,
  output logic [DW-1:0] samp_b,
  output logic          state_a,
  output logic          state_b,
  output logic          gap_a,
  output logic          gap_b,
  input  logic          gap_clr_a,
  input  logic          gap_clr_b
);
  logic [CW-1:0]              cnt;
  logic [PF_DUAL-1:0][DW-1:0] head;
  logic [POPW-1:0]            pop_n;
  logic [NCH-1:0][DW-1:0]     samp;
  logic [NCH-1:0]             gap, state;
  logic                       stop_hit, live;

  pwm_wfifo_mem #(.DW(DW), .DEPTH(DEPTH), .NRD(PF_DUAL)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_valid & wr_ready),
    .push_data(wr_data),
    .pop_n    (pop_n),
    .cnt      (cnt),
    .head     (head)
  );

  pwm_wfifo_req #(.DEPTH(DEPTH)) u_req (
    .cnt  (cnt),
    .thr  (dreq_thr),
    .dreq (dreq),
    .empty(empty),
    .ready(wr_ready)
  );

  pwm_wfifo_feed #(.DW(DW), .DEPTH(DEPTH)) u_feed (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      ({en_b, en_a}),
    .rpt     ({rpt_b, rpt_a}),
    .strobe  ({strobe_b, strobe_a}),
    .cnt     (cnt),
    .head    (head),
    .samp    (samp),
    .pop_n   (pop_n),
    .stop_hit(stop_hit),
    .live    (live)
  );

  pwm_wfifo_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop_hit(stop_hit),
    .live    (live),
    .en      ({en_b, en_a}),
    .gap_clr ({gap_clr_b, gap_clr_a}),
    .gap     (gap),
    .state   (state)
  );

  assign samp_a  = samp[0];
  assign samp_b  = samp[1];
  assign gap_a   = gap[0];
  assign gap_b   = gap[1];
  assign state_a = state[0];
  assign state_b = state[1];
endmodule

// File: rtl/pwm_wfifo_chk.sv
module pwm_wfifo_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [CW-1:0] dreq_thr,
  input logic          dreq,
  input logic          empty,
  input logic          en_a,
  input logic          en_b,
  input logic          strobe_a,
  input logic [DW-1:0] samp_a,
  input logic          state_a,
  input logic          state_b,
  input logic          gap_a,
  input logic          gap_b,
  input logic          gap_clr_a,
  input logic          gap_clr_b
);
  AST_EMPTY_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && dreq_thr != '0) |-> dreq);  // R1
  AST_ZERO_THR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq_thr == '0) |-> !dreq);  // R2
  AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !empty);  // R3
  AST_REFUSED_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && wr_valid && !en_a && !en_b) |=> !wr_ready);  // R4
  AST_SINGLE_SAMPLE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_a && !en_b && !strobe_a) |=> (!(en_a && !en_b) || $stable(samp_a)));  // R6
  AST_SINGLE_STAYS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && !en_b) |=> (!(en_a && !en_b) || state_a));  // R7
  AST_STOP_RAISES_GAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_a && state_b) |=> (state_a || !(en_a && en_b) || (gap_a && gap_b)));  // R10
  AST_GAP_A_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_a && !gap_clr_a) |=> gap_a);  // R12
  AST_GAP_B_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_b && !gap_clr_b) |=> gap_b);  // R12
  AST_OFF_NOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_a && !en_b) |-> (!state_a && !state_b));  // R13
endmodule

bind pwm_wfifo pwm_wfifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .dreq_thr (dreq_thr),
  .dreq     (dreq),
  .empty    (empty),
  .en_a     (en_a),
  .en_b     (en_b),
  .strobe_a (strobe_a),
  .samp_a   (samp_a),
  .state_a  (state_a),
  .state_b  (state_b),
  .gap_a    (gap_a),
  .gap_b    (gap_b),
  .gap_clr_a(gap_clr_a),
  .gap_clr_b(gap_clr_b)
);

// File: tb/pwm_wfifo_bench.sv
module pwm_wfifo_bench;
  localparam int  DW    = 32;
  localparam int  DEPTH = 8;
  localparam int  CW    = $clog2(DEPTH + 1);
  localparam time TCK   = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic [CW-1:0] dreq_thr = '0;
  logic dreq, empty;
  logic en_a = 0, en_b = 0, rpt_a = 0, rpt_b = 0, strobe_a = 0, strobe_b = 0;
  logic [DW-1:0] samp_a, samp_b;
  logic state_a, state_b, gap_a, gap_b;
  logic gap_clr_a = 0, gap_clr_b = 0;

  pwm_wfifo #(.DW(DW), .DEPTH(DEPTH)) u_pwm_wfifo (.*);

  always #(TCK/2) clk = ~clk;

  // reference model state
  logic [DW-1:0] q[$];
  logic [DW-1:0] m_cur [2] = '{default: '0};
  logic [DW-1:0] m_hold [2] = '{default: '0};
  bit m_hv [2] = '{default: 0};
  bit m_gap [2] = '{default: 0};
  bit m_act = 0, m_stop = 0, m_nxt = 0;
  string tag = "R3";
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string t, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %h expected %h", t, what, got, exp);
    end
  endtask

  task automatic model_step();
    int n, c, tgt;
    bit any, dual, rep, hit;
    bit [1:0] en, stb, clr;
    n = q.size(); en = {en_b, en_a}; stb = {strobe_b, strobe_a}; clr = {gap_clr_b, gap_clr_a};
    any = |en; dual = &en; rep = rpt_a & rpt_b; c = (en_b && !en_a) ? 1 : 0; hit = 0;
    if (!any) begin
      m_hv[0] = 0; m_hv[1] = 0; m_stop = 0;
    end else if (!m_act) begin
      m_stop = 0; m_nxt = 0; m_hv[0] = 0; m_hv[1] = 0;
      if (dual) begin
        m_cur[0] = (n > 0) ? q[0] : '0;
        m_cur[1] = (n > 1) ? q[1] : '0;
        if (n > 2) begin m_hold[0] = q[2]; m_hv[0] = 1; end
        if (n > 3) begin m_hold[1] = q[3]; m_hv[1] = 1; end
        repeat ((n > 4) ? 4 : n) void'(q.pop_front());
      end else begin
        m_cur[c] = (n > 0) ? q[0] : '0;
        if (n > 1) begin m_hold[c] = q[1]; m_hv[c] = 1; end
        repeat ((n > 2) ? 2 : n) void'(q.pop_front());
      end
    end else if (!m_stop) begin
      for (int ch = 0; ch < 2; ch++) begin
        if (stb[ch] && en[ch]) begin
          if (m_hv[ch]) begin m_cur[ch] = m_hold[ch]; m_hv[ch] = 0; end
          else if (dual && !rep) hit = 1;
        end
      end
      if (hit) m_stop = 1;
      else begin
        tgt = dual ? int'(m_nxt) : c;
        if (!m_hv[tgt] && n > 0) begin
          m_hold[tgt] = q.pop_front(); m_hv[tgt] = 1;
          if (dual) m_nxt = !m_nxt;
        end
      end
    end
    for (int ch = 0; ch < 2; ch++) begin
      if (hit) m_gap[ch] = 1;
      else if (clr[ch]) m_gap[ch] = 0;
    end
    m_act = any;
    if (wr_valid && n < DEPTH) q.push_back(wr_data);
  endtask

  task automatic compare();
    bit live;
    live = m_act && !m_stop;
    chk((dreq_thr == 0) ? "R2" : "R1", "dreq", DW'(dreq), DW'(q.size() < int'(dreq_thr)));
    chk("R3", "empty", DW'(empty), DW'(q.size() == 0));
    chk("R4", "wr_ready", DW'(wr_ready), DW'(q.size() < DEPTH));
    chk(tag, "samp_a", samp_a, m_cur[0]);
    chk(tag, "samp_b", samp_b, m_cur[1]);
    chk(tag, "state_a", DW'(state_a), DW'(en_a && live));
    chk(tag, "state_b", DW'(state_b), DW'(en_b && live));
    chk(tag, "gap_a", DW'(gap_a), DW'(m_gap[0]));
    chk(tag, "gap_b", DW'(gap_b), DW'(m_gap[1]));
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    compare();
  endtask

  // n cycles with given mode and percentages for write, strobe, gap clear
  task automatic run(string t, int n, bit [1:0] en, bit [1:0] rpt, int p_wr, int p_stb, int p_clr);
    tag = t;
    for (int i = 0; i < n; i++) begin
      en_a = en[0]; en_b = en[1]; rpt_a = rpt[0]; rpt_b = rpt[1];
      wr_valid  = $urandom_range(99) < p_wr;
      wr_data   = $urandom;
      strobe_a  = $urandom_range(99) < p_stb;
      strobe_b  = $urandom_range(99) < p_stb;
      gap_clr_a = $urandom_range(99) < p_clr;
      gap_clr_b = $urandom_range(99) < p_clr;
      cyc();
    end
  endtask

  initial begin
    #(TCK * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c4a));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    compare();                                   // R3 reset state
    dreq_thr = 3;
    run("R1", 6, 2'b00, 2'b00, 50, 0, 0);
    run("R4", 12, 2'b00, 2'b00, 100, 0, 0);      // fills, then refused
    dreq_thr = 0;
    run("R2", 5, 2'b00, 2'b00, 0, 0, 0);
    dreq_thr = 9;
    run("R1", 2, 2'b00, 2'b00, 0, 0, 0);         // full yet below 9
    dreq_thr = 4;
    run("R5", 3, 2'b01, 2'b00, 0, 0, 0);         // start with 8 stored
    run("R6", 60, 2'b01, 2'b00, 40, 60, 0);
    run("R7", 20, 2'b01, 2'b11, 0, 100, 0);      // drain and repeat
    run("R13", 2, 2'b00, 2'b00, 0, 50, 0);
    run("R5", 1, 2'b00, 2'b00, 100, 0, 0);       // exactly one word
    run("R5", 3, 2'b10, 2'b00, 0, 0, 0);
    run("R6", 40, 2'b10, 2'b01, 40, 50, 0);
    run("R13", 1, 2'b00, 2'b00, 0, 0, 0);
    run("R8", 10, 2'b00, 2'b00, 100, 0, 0);      // full before dual start
    run("R8", 2, 2'b11, 2'b00, 0, 0, 0);
    run("R9", 60, 2'b11, 2'b00, 90, 50, 0);
    run("R10", 30, 2'b11, 2'b01, 0, 50, 0);      // underrun stops
    run("R12", 3, 2'b00, 2'b00, 0, 0, 0);
    tag = "R12"; gap_clr_a = 1; cyc(); gap_clr_a = 0; cyc();
    gap_clr_b = 1; cyc(); gap_clr_b = 0; cyc();
    run("R13", 25, 2'b01, 2'b00, 0, 100, 0);     // empty the queue
    run("R13", 1, 2'b00, 2'b00, 0, 0, 0);
    run("R8", 1, 2'b00, 2'b00, 100, 0, 0);       // one word stored
    run("R8", 3, 2'b11, 2'b00, 0, 0, 0);
    run("R11", 60, 2'b11, 2'b11, 30, 60, 0);
    run("R10", 20, 2'b11, 2'b00, 0, 70, 0);
    for (int r = 0; r < 24; r++) begin
      bit [1:0] en, rpt;
      en  = 2'($urandom_range(1, 3));
      rpt = 2'($urandom_range(0, 3));
      dreq_thr = CW'($urandom_range(0, 9));
      run("R13", 1, 2'b00, 2'b00, 50, 0, 10);
      run((en != 2'b11) ? "R6" : ((rpt == 2'b11) ? "R11" : "R9"),
          $urandom_range(10, 50), en, rpt, $urandom_range(20, 90), $urandom_range(10, 80), 5);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule